// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller for a dual-slope analog-to-digital converter. A processor-side enable bit switches the converter on and off. Each write of 1 to that bit starts a fresh conversion from the zeroing phase. Each conversion has three phases. First comes auto-zero, then a fixed period in which the integrator charges from the input, then a reverse period in which it discharges against the reference. The block drives one control line per phase and a power-enable line toward the analog side.

During the reverse period a 13-bit counter runs from zero. It stops when the comparator input reports a zero crossing, or when it reaches a maximum count. At that point the count and the input polarity are captured into a result register. An interrupt flag is then set, and the interrupt request is gated by a mask bit. While the enable bit stays at 1, the next conversion starts on its own.

Top module: `dsadc_sequencer`

## Requirements
- R1: Writing 1 through `en_wr_i`/`en_wdata_i` sets `enable_o` and `pwr_en_o` to 1 in the next cycle. Writing 0 clears both and forces all three phase outputs to 0 in the next cycle.
- R2: After an enable write of 1, `phase_az_o` is high for exactly AZ_CYC cycles. Then `phase_int_o` is high for exactly INT_CYC cycles. Then `phase_rev_o` goes high. At most one phase output is high at any time.
- R3: The count is 0 in the first reverse cycle and rises by one in each further reverse cycle. If `cmp_zero_i` is high in a reverse cycle where the count is k, `result_o` reads k from the next cycle on.
- R4: If no crossing occurs, the reverse phase ends in the cycle where the count equals REV_MAX, so it lasts REV_MAX+1 cycles, and REV_MAX is latched.
- R5: `polarity_o` is latched together with the count from `cmp_pos_i`: 1 means a positive input and 0 a negative one.
- R6: An enable write of 1 during a conversion abandons it. The next cycle is in auto-zero, and no result or flag is updated. The next reverse phase counts from 0 again.
- R7: `flag_o` is set in the cycle after the reverse phase ends, whatever the value of `mask_o`.
- R8: `irq_o` is 1 exactly when both `flag_o` and `mask_o` are 1. The mask is written through `mask_wr_i`/`mask_wdata_i`.
- R9: A pulse on `flag_rd_i` clears `flag_o` in the next cycle. If the flag is set and read in the same cycle, the set wins.
- R10: When a conversion completes and the enable bit is still 1, the next cycle is in auto-zero.
- R11: Reset drives all outputs to 0.
- R12: `result_o` and `polarity_o` hold their value until the next completed conversion, including while the converter is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| mask_wr_i | input | 1 | Write strobe for the interrupt mask |
| mask_wdata_i | input | 1 | Value written to the interrupt mask |
| flag_rd_i | input | 1 | Processor read of the interrupt flag (clears it) |
| cmp_zero_i | input | 1 | Comparator reports integrator zero crossing |
| cmp_pos_i | input | 1 | Input polarity, 1 = positive |
| enable_o | output | 1 | Enable bit readback |
| pwr_en_o | output | 1 | Analog power enable |
| phase_az_o | output | 1 | Auto-zero phase active |
| phase_int_o | output | 1 | Input integration phase active |
| phase_rev_o | output | 1 | Reverse integration phase active |
| result_o | output | 13 | Latched count |
| polarity_o | output | 1 | Latched polarity |
| flag_o | output | 1 | Interrupt flag |
| mask_o | output | 1 | Interrupt mask |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the write strobes and the flag read are single-cycle pulses that are sampled at a clock edge. They also assume that `cmp_zero_i` has meaning only in the reverse phase, so a crossing seen in any other phase is ignored. The stimulus drives every input on the falling edge. It raises the comparator only after the bench has seen the reverse phase and waited for the wanted count. It spaces mask and flag accesses so that they never overlap a restart, except in the directed cases built to test exactly that collision.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_AZ   = 2'd1,
    PH_INT  = 2'd2,
    PH_REV  = 2'd3
  } phase_e;
endpackage

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
  import dsadc_pkg::*;
#(
  parameter int unsigned AZ_CYC  = 4,
  parameter int unsigned INT_CYC = 8,
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned REV_MAX = (1 << CNT_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_wr_i,
  input  logic             en_wdata_i,
  input  logic             cmp_zero_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             en_o,
  output phase_e           phase_o,
  output logic             clear_o,
  output logic             done_o
);
  localparam int unsigned LONGEST = (AZ_CYC > INT_CYC) ? AZ_CYC : INT_CYC;
  localparam int unsigned TMR_W   = $clog2(LONGEST + 1);

  logic             en_q;
  phase_e           phase_q;
  logic [TMR_W-1:0] tmr_q;
  logic             az_end, int_end;

  assign az_end  = (phase_q == PH_AZ)  && (tmr_q == TMR_W'(AZ_CYC - 1));
  assign int_end = (phase_q == PH_INT) && (tmr_q == TMR_W'(INT_CYC - 1));
  // a write of either value aborts the running conversion
  assign done_o  = (phase_q == PH_REV) && !en_wr_i &&
                   (cmp_zero_i || count_i == CNT_W'(REV_MAX));
  assign clear_o = (en_wr_i && en_wdata_i) || (int_end && !en_wr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
    end else if (en_wr_i) begin
      en_q    <= en_wdata_i;
      phase_q <= en_wdata_i ? PH_AZ : PH_IDLE;
      tmr_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_AZ: begin
          phase_q <= az_end ? PH_INT : PH_AZ;
          tmr_q   <= az_end ? '0 : tmr_q + 1'b1;
        end
        PH_INT: begin
          phase_q <= int_end ? PH_REV : PH_INT;
          tmr_q   <= int_end ? '0 : tmr_q + 1'b1;
        end
        PH_REV: if (done_o) phase_q <= PH_AZ;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign en_o    = en_q;
  assign phase_o = phase_q;

  assert_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && !en_wdata_i) |=> (phase_q == PH_IDLE && !en_q));
  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && en_wdata_i) |=> (phase_q == PH_AZ && tmr_q == '0));
  assert_az_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_AZ) |-> (tmr_q < TMR_W'(AZ_CYC)));
  assert_auto_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (phase_q == PH_AZ));
endmodule

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             done_i,
  input  logic             cmp_pos_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] result_o,
  output logic             pol_o
);
  logic [CNT_W-1:0] cnt_q, res_q;
  logic             pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      res_q <= '0;
      pol_q <= 1'b0;
    end else begin
      if (clear_i)                cnt_q <= '0;
      else if (run_i && !done_i)  cnt_q <= cnt_q + 1'b1;
      if (done_i) begin
        res_q <= cnt_q;
        pol_q <= cmp_pos_i;
      end
    end
  end

  assign count_o  = cnt_q;
  assign result_o = res_q;
  assign pol_o    = pol_q;

  assert_zero_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_q == '0));
  assert_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (res_q == $past(cnt_q) && pol_q == $past(cmp_pos_i)));
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> ($stable(res_q) && $stable(pol_q)));
endmodule

// File: rtl/dsadc_irq.sv
module dsadc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic flag_rd_i,
  input  logic mask_wr_i,
  input  logic mask_wdata_i,
  output logic flag_o,
  output logic mask_o,
  output logic irq_o
);
  logic flag_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (set_i)          flag_q <= 1'b1;
      else if (flag_rd_i) flag_q <= 1'b0;
      if (mask_wr_i)      mask_q <= mask_wdata_i;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = flag_q & mask_q;

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  assert_rd_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && !set_i) |=> !flag_q);
  assert_set_unmasked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !mask_q && !mask_wr_i) |=> (flag_q && !irq_o));
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
  import dsadc_pkg::*;
#(
  parameter int unsigned AZ_CYC  = 4,
  parameter int unsigned INT_CYC = 8,
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned REV_MAX = (1 << CNT_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_wr_i,
  input  logic             en_wdata_i,
  input  logic             mask_wr_i,
  input  logic             mask_wdata_i,
  input  logic             flag_rd_i,
  input  logic             cmp_zero_i,
  input  logic             cmp_pos_i,
  output logic             enable_o,
  output logic             pwr_en_o,
  output logic             phase_az_o,
  output logic             phase_int_o,
  output logic             phase_rev_o,
  output logic [CNT_W-1:0] result_o,
  output logic             polarity_o,
  output logic             flag_o,
  output logic             mask_o,
  output logic             irq_o
);
  phase_e           phase;
  logic             en, clear, done;
  logic [CNT_W-1:0] count;

  dsadc_phase_ctrl #(
    .AZ_CYC(AZ_CYC), .INT_CYC(INT_CYC), .CNT_W(CNT_W), .REV_MAX(REV_MAX)
  ) u_ctrl (
    .clk_i, .rst_ni, .en_wr_i, .en_wdata_i, .cmp_zero_i,
    .count_i(count), .en_o(en), .phase_o(phase), .clear_o(clear), .done_o(done)
  );

  dsadc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clear_i(clear), .run_i(phase == PH_REV), .done_i(done),
    .cmp_pos_i, .count_o(count), .result_o, .pol_o(polarity_o)
  );

  dsadc_irq u_irq (
    .clk_i, .rst_ni, .set_i(done), .flag_rd_i, .mask_wr_i, .mask_wdata_i,
    .flag_o, .mask_o, .irq_o
  );

  assign enable_o    = en;
  assign pwr_en_o    = en;
  assign phase_az_o  = (phase == PH_AZ);
  assign phase_int_o = (phase == PH_INT);
  assign phase_rev_o = (phase == PH_REV);

  assert_one_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({phase_az_o, phase_int_o, phase_rev_o}));
  assert_unpowered_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> !(phase_az_o || phase_int_o || phase_rev_o));
  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && mask_o));
endmodule

// File: tb/dsadc_sequencer_tb.sv
module dsadc_sequencer_tb;
  localparam int unsigned AZ_CYC  = 4;
  localparam int unsigned INT_CYC = 8;
  localparam int unsigned CNT_W   = 13;
  localparam int unsigned REV_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en_wr = 0, en_wdata = 0, mask_wr = 0, mask_wdata = 0, flag_rd = 0;
  logic cmp_zero = 0, cmp_pos = 0;
  logic enable, pwr_en, ph_az, ph_int, ph_rev, polarity, flag, mask, irq;
  logic [CNT_W-1:0] result;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dsadc_sequencer #(.AZ_CYC(AZ_CYC), .INT_CYC(INT_CYC), .CNT_W(CNT_W), .REV_MAX(REV_MAX)) u_dut (
    .clk_i(clk), .rst_ni, .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata), .flag_rd_i(flag_rd),
    .cmp_zero_i(cmp_zero), .cmp_pos_i(cmp_pos),
    .enable_o(enable), .pwr_en_o(pwr_en), .phase_az_o(ph_az), .phase_int_o(ph_int),
    .phase_rev_o(ph_rev), .result_o(result), .polarity_o(polarity),
    .flag_o(flag), .mask_o(mask), .irq_o(irq)
  );

  typedef struct packed {
    logic [CNT_W-1:0] k;
    logic             pos;
    logic             msk;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{13'd0,   1'b1, 1'b1},
    '{13'd1,   1'b0, 1'b0},
    '{13'd37,  1'b1, 1'b1},
    '{13'd200, 1'b0, 1'b1},
    '{13'd3,   1'b1, 1'b0},
    '{13'd1000,1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_en(input logic v);
    en_wr = 1; en_wdata = v; @(negedge clk); en_wr = 0;
  endtask
  task automatic wr_mask(input logic v);
    mask_wr = 1; mask_wdata = v; @(negedge clk); mask_wr = 0;
  endtask
  task automatic rd_flag();
    flag_rd = 1; @(negedge clk); flag_rd = 0;
  endtask
  task automatic wait_rev();
    while (!ph_rev) @(negedge clk);
  endtask
  // cross zero when count == k; rd also reads the flag in the same cycle
  task automatic convert(input int k, input logic pos, input logic rd);
    wait_rev();
    repeat (k) @(negedge clk);
    cmp_pos = pos; cmp_zero = 1; flag_rd = rd;
    @(negedge clk);
    cmp_zero = 0; flag_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic [CNT_W-1:0] held;
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {enable, pwr_en, ph_az, ph_int, ph_rev, polarity, flag, mask, irq}, 0);
    check("R11 reset result", 32'(result), 0);
    rst_ni = 1;
    @(negedge clk);

    // R1, R2: enable and phase lengths
    wr_en(1);
    check("R1 enable readback", {enable, pwr_en}, 2'b11);
    n = 0; while (ph_az) begin n++; @(negedge clk); end
    check("R2 auto-zero length", n, AZ_CYC);
    n = 0; while (ph_int) begin n++; @(negedge clk); end
    check("R2 integrate length", n, INT_CYC);
    check("R2 reverse follows", ph_rev, 1);
    // R3, R7, R10: first conversion with mask 0
    convert(5, 1'b1, 1'b0);
    check("R3 latched count", 32'(result), 5);
    check("R7 flag set while masked", flag, 1);
    check("R8 irq masked", irq, 0);
    check("R10 auto restart", ph_az, 1);
    rd_flag();
    check("R9 read clears flag", flag, 0);

    // vector table
    foreach (VECS[i]) begin
      wr_mask(VECS[i].msk);
      rd_flag();
      convert(int'(VECS[i].k), VECS[i].pos, 1'b0);
      check("R3 table result", 32'(result), 32'(VECS[i].k));
      check("R5 table polarity", polarity, VECS[i].pos);
      check("R7 table flag", flag, 1);
      check("R8 table irq", irq, VECS[i].msk);
    end

    // R9 set wins over simultaneous read (flag already 1)
    convert(9, 1'b1, 1'b1);
    check("R9 set wins", flag, 1);
    check("R3 result after collision", 32'(result), 9);

    // R6 restart mid-reverse
    rd_flag();
    held = result;
    wait_rev();
    repeat (3) @(negedge clk);
    wr_en(1);
    check("R6 back in auto-zero", ph_az, 1);
    check("R6 no flag on abort", flag, 0);
    check("R6 result untouched", 32'(result), 32'(held));
    n = 0; while (ph_az) begin n++; @(negedge clk); end
    check("R6 full auto-zero after restart", n, AZ_CYC);
    convert(2, 1'b0, 1'b0);
    check("R6 count restarts from zero", 32'(result), 2);

    // R4 timeout
    rd_flag();
    wait_rev();
    n = 0; while (ph_rev) begin n++; @(negedge clk); end
    check("R4 reverse length at timeout", n, REV_MAX + 1);
    check("R4 timeout result", 32'(result), REV_MAX);
    check("R4 timeout flag", flag, 1);

    // R1, R12 disable
    rd_flag();
    held = result;
    wait_rev();
    @(negedge clk);
    wr_en(0);
    check("R1 disable readback", {enable, pwr_en}, 2'b00);
    check("R1 phases off", {ph_az, ph_int, ph_rev}, 3'b000);
    cmp_zero = 1;
    repeat (20) @(negedge clk);
    cmp_zero = 0;
    check("R12 result held while off", 32'(result), 32'(held));
    check("R1 stays idle", {ph_az, ph_int, ph_rev, flag}, 4'b0000);
    wr_en(1);
    check("R1 re-enable powers", {pwr_en, ph_az}, 2'b11);

    // R11 reset while running
    wr_mask(1);
    rst_ni = 0;
    @(negedge clk);
    check("R11 reset mid-run", {enable, pwr_en, ph_az, ph_int, ph_rev, mask, irq}, 0);
    check("R11 reset clears result", 32'(result), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule